// File: doc/BRIEF.md
# Gated Decade Counter

This block is a four-bit ripple counter split into two independent sections. A divide-by-two section advances on every falling edge of `tick_a` and drives `half_out`. A divide-by-five section advances on every falling edge of `tick_b` and drives the three-bit `quin_out`. The counter value is read as `{quin_out, half_out}`, with `quin_out[2]` as the most significant bit. Each section is a small state machine. The half section has the states HALF_LO and HALF_HI and swaps between them on each falling edge. The quinary section walks QN_S0 -> QN_S1 -> QN_S2 -> QN_S3 -> QN_S4 and wraps from QN_S4 back to QN_S0.

The sections are chained outside the block. Feeding `half_out` into `tick_b` and counting on `tick_a` gives a decade counter in BCD order. Feeding `quin_out[2]` into `tick_a` and counting on `tick_b` gives a square wave on `half_out` at one tenth of the input rate, with equal high and low times.

Two gated, asynchronous overrides act on both sections. The zero override forces both sections to their first state. It acts only while both `zero_req_0` and `zero_req_1` are high. The nine override forces HALF_HI and QN_S4, which reads as value 9. It acts only while both `nine_req_0` and `nine_req_1` are high. An override holds the outputs for as long as it stays active, and the nine override wins when both are active.

Top module: `gated_decade_counter`

## Requirements
- R1: `half_out` inverts on each falling edge of `tick_a`. A rising edge of `tick_a` leaves it unchanged.
- R2: On successive falling edges of `tick_b`, `quin_out` steps through the binary values 0, 1, 2, 3 and 4, then returns to 0. A rising edge of `tick_b` leaves it unchanged.
- R3: With `tick_b` driven by `half_out`, falling edges on `tick_a` make `{quin_out, half_out}` count 0 to 9 in BCD order and then wrap to 0.
- R4: With `tick_a` driven by `quin_out[2]`, `half_out` changes level once every five falling edges of `tick_b`. It is low for edges 1 to 4 after a clear and high for edges 5 to 9.
- R5: `quin_out` never shows a value above 4.
- R6: When both `zero_req_0` and `zero_req_1` are high and the nine override is inactive, all outputs go to 0 at once. They stay 0 while the override is active, whatever edges arrive on the tick inputs.
- R7: When both `nine_req_0` and `nine_req_1` are high, `half_out` goes to 1 and `quin_out` goes to 3'b100 (value 9) at once. They stay there while the override is active, whatever edges arrive on the tick inputs.
- R8: When both overrides are active together, the value is 9. If the nine override is then released while the zero override stays active, the value goes to 0.
- R9: A request pair with only one input high has no effect: counting continues normally.
- R10: After an override is released, counting resumes from the forced value. In BCD chaining, a falling edge from 9 gives 0, and a falling edge from 0 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tick_a | input | 1 | Count input of the divide-by-two section, active on its falling edge |
| tick_b | input | 1 | Count input of the divide-by-five section, active on its falling edge |
| zero_req_0 | input | 1 | First input of the gated clear pair |
| zero_req_1 | input | 1 | Second input of the gated clear pair |
| nine_req_0 | input | 1 | First input of the gated set-to-nine pair |
| nine_req_1 | input | 1 | Second input of the gated set-to-nine pair |
| half_out | output | 1 | Divide-by-two output, bit 0 of the value |
| quin_out | output | 3 | Divide-by-five output, bits 3..1 of the value |

## Verification
No result waits for a clock. A count appears in the same time step as the falling tick edge that causes it, including the ripple through an external chain. An override appears in the same time step as the second request input of its pair. The bench drives each tick fall on a falling bench-clock edge and reads the outputs one nanosecond after the next rising edge, 5 ns later. After changing a request input it waits 2 ns before reading. No check therefore shares a time step with the edge that causes it. For the rising-edge cases, the bench reads the outputs after the tick has risen and before it falls, so that only the rising edge has happened.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
    localparam int QUIN_W = 3;
    localparam int VAL_W  = QUIN_W + 1;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_st_e;

    typedef enum logic [QUIN_W-1:0] {
        QN_S0 = 3'd0,
        QN_S1 = 3'd1,
        QN_S2 = 3'd2,
        QN_S3 = 3'd3,
        QN_S4 = 3'd4
    } quin_st_e;
endpackage

// File: rtl/gdc_force_gate.sv
module gdc_force_gate (
    input  logic zero_req_0,
    input  logic zero_req_1,
    input  logic nine_req_0,
    input  logic nine_req_1,
    output logic force_zero,
    output logic force_nine
);
    logic nine_pair;
    logic zero_pair;

    always_comb begin
        nine_pair  = nine_req_0 & nine_req_1;
        zero_pair  = zero_req_0 & zero_req_1;
        force_nine = nine_pair;
        // Clear is masked by the nine override, so when nine drops while the
        // clear pair is still high, force_zero rises and takes over.
        force_zero = zero_pair & ~nine_pair;
    end
endmodule

// File: rtl/gdc_half_stage.sv
module gdc_half_stage
    import gdc_pkg::*;
(
    input  logic tick_n,
    input  logic force_zero,
    input  logic force_nine,
    output logic bit_out
);
    half_st_e st_q;
    half_st_e st_d;

    always_comb begin
        unique case (st_q)
            HALF_LO: st_d = HALF_HI;
            HALF_HI: st_d = HALF_LO;
            default: st_d = HALF_LO;
        endcase
    end

    always_ff @(negedge tick_n or posedge force_zero or posedge force_nine) begin
        if (force_nine)
            st_q <= HALF_HI;
        else if (force_zero)
            st_q <= HALF_LO;
        else
            st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            HALF_LO: bit_out = 1'b0;
            HALF_HI: bit_out = 1'b1;
            default: bit_out = 1'b0;
        endcase
    end

    // R6
    half_zero_held_chk: assert property (@(negedge force_zero) disable iff (force_nine)
        st_q == HALF_LO);
    // R7
    half_nine_held_chk: assert property (@(negedge force_nine) disable iff (force_zero)
        st_q == HALF_HI);
endmodule

// File: rtl/gdc_quin_stage.sv
module gdc_quin_stage
    import gdc_pkg::*;
(
    input  logic              tick_n,
    input  logic              force_zero,
    input  logic              force_nine,
    output logic [QUIN_W-1:0] code_out
);
    quin_st_e st_q;
    quin_st_e st_d;

    always_comb begin
        unique case (st_q)
            QN_S0:   st_d = QN_S1;
            QN_S1:   st_d = QN_S2;
            QN_S2:   st_d = QN_S3;
            QN_S3:   st_d = QN_S4;
            QN_S4:   st_d = QN_S0;
            default: st_d = QN_S0;
        endcase
    end

    always_ff @(negedge tick_n or posedge force_zero or posedge force_nine) begin
        if (force_nine)
            st_q <= QN_S4;
        else if (force_zero)
            st_q <= QN_S0;
        else
            st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            QN_S0:   code_out = 3'd0;
            QN_S1:   code_out = 3'd1;
            QN_S2:   code_out = 3'd2;
            QN_S3:   code_out = 3'd3;
            QN_S4:   code_out = 3'd4;
            default: code_out = 3'd0;
        endcase
    end

    // R5
    quin_range_chk: assert property (@(negedge tick_n) disable iff (force_zero || force_nine)
        code_out <= 3'd4);
    // R6
    quin_zero_held_chk: assert property (@(negedge force_zero) disable iff (force_nine)
        code_out == 3'd0);
    // R7
    quin_nine_held_chk: assert property (@(negedge force_nine) disable iff (force_zero)
        code_out == 3'd4);
endmodule

// File: rtl/gated_decade_counter.sv
module gated_decade_counter
    import gdc_pkg::*;
(
    input  logic              tick_a,
    input  logic              tick_b,
    input  logic              zero_req_0,
    input  logic              zero_req_1,
    input  logic              nine_req_0,
    input  logic              nine_req_1,
    output logic              half_out,
    output logic [QUIN_W-1:0] quin_out
);
    logic force_zero;
    logic force_nine;

    gdc_force_gate u_gate (
        .zero_req_0 (zero_req_0),
        .zero_req_1 (zero_req_1),
        .nine_req_0 (nine_req_0),
        .nine_req_1 (nine_req_1),
        .force_zero (force_zero),
        .force_nine (force_nine)
    );

    gdc_half_stage u_half (
        .tick_n     (tick_a),
        .force_zero (force_zero),
        .force_nine (force_nine),
        .bit_out    (half_out)
    );

    gdc_quin_stage u_quin (
        .tick_n     (tick_b),
        .force_zero (force_zero),
        .force_nine (force_nine),
        .code_out   (quin_out)
    );
endmodule

// File: tb/gated_decade_counter_bench.sv
module gated_decade_counter_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       a_drv = 1'b0;
    logic       b_drv = 1'b0;
    logic [1:0] mode  = 2'd0;
    logic zr0 = 1'b1, zr1 = 1'b1, nr0 = 1'b0, nr1 = 1'b0;
    logic       half_out;
    logic [2:0] quin_out;
    logic       tick_a, tick_b;
    logic [3:0] val;

    int n_run  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    // mode 0: tick inputs driven directly; 1: BCD chain; 2: divide-by-ten square wave chain
    assign tick_a = (mode == 2'd2) ? quin_out[2] : a_drv;
    assign tick_b = (mode == 2'd1) ? half_out    : b_drv;
    assign val    = {quin_out, half_out};

    gated_decade_counter u_gated_decade_counter (
        .tick_a     (tick_a),
        .tick_b     (tick_b),
        .zero_req_0 (zr0),
        .zero_req_1 (zr1),
        .nine_req_0 (nr0),
        .nine_req_1 (nr1),
        .half_out   (half_out),
        .quin_out   (quin_out)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       on_b;
        logic [4:0] npulse;
        logic [3:0] expv;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VEC [NVEC] = '{
        '{2'd1, 1'b0, 5'd1,  4'd1, 4'd3},   // R3
        '{2'd1, 1'b0, 5'd2,  4'd2, 4'd3},   // R3
        '{2'd1, 1'b0, 5'd5,  4'd5, 4'd3},   // R3
        '{2'd1, 1'b0, 5'd9,  4'd9, 4'd3},   // R3
        '{2'd1, 1'b0, 5'd10, 4'd0, 4'd3},   // R3 wrap
        '{2'd1, 1'b0, 5'd13, 4'd3, 4'd3},   // R3
        '{2'd0, 1'b0, 5'd1,  4'd1, 4'd1},   // R1
        '{2'd0, 1'b0, 5'd2,  4'd0, 4'd1},   // R1
        '{2'd0, 1'b0, 5'd3,  4'd1, 4'd1},   // R1
        '{2'd0, 1'b1, 5'd1,  4'd2, 4'd2},   // R2
        '{2'd0, 1'b1, 5'd4,  4'd8, 4'd2},   // R2
        '{2'd0, 1'b1, 5'd5,  4'd0, 4'd2},   // R2 wrap
        '{2'd0, 1'b1, 5'd7,  4'd4, 4'd2},   // R2
        '{2'd2, 1'b1, 5'd4,  4'd8, 4'd4},   // R4
        '{2'd2, 1'b1, 5'd5,  4'd1, 4'd4},   // R4
        '{2'd2, 1'b1, 5'd9,  4'd9, 4'd4},   // R4
        '{2'd2, 1'b1, 5'd10, 4'd0, 4'd4}    // R4
    };

    task automatic check(input logic [3:0] got, input logic [3:0] expv, input string tag);
        n_run++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic pulse(input logic on_b);
        @(posedge clk);
        if (on_b) b_drv = 1'b1; else a_drv = 1'b1;
        @(negedge clk);
        if (on_b) b_drv = 1'b0; else a_drv = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic enter_mode(input logic [1:0] m);
        zr0 = 1'b1; zr1 = 1'b1; nr0 = 1'b0; nr1 = 1'b0;
        #2;
        a_drv = 1'b0; b_drv = 1'b0; mode = m;
        #2;
        zr0 = 1'b0; zr1 = 1'b0;
        #2;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #3;
        check(val, 4'd0, "R6 reset state");

        for (int i = 0; i < NVEC; i++) begin
            enter_mode(VEC[i].mode);
            for (int k = 0; k < int'(VEC[i].npulse); k++) pulse(VEC[i].on_b);
            check(val, VEC[i].expv, $sformatf("R%0d vector %0d", VEC[i].req, i));
        end

        // R1 / R2: rising edges do not count
        enter_mode(2'd0);
        a_drv = 1'b1; #2;
        check(val, 4'd0, "R1 rising edge");
        a_drv = 1'b0; #2;
        check(val, 4'd1, "R1 falling edge");
        b_drv = 1'b1; #2;
        check(val, 4'd1, "R2 rising edge");
        b_drv = 1'b0; #2;
        check(val, 4'd3, "R2 falling edge");

        // R7 / R10 in BCD chain
        enter_mode(2'd1);
        for (int k = 0; k < 3; k++) pulse(1'b0);
        nr0 = 1'b1; nr1 = 1'b1; #2;
        check(val, 4'd9, "R7 set to nine");
        for (int k = 0; k < 3; k++) pulse(1'b0);
        check(val, 4'd9, "R7 nine held");
        nr0 = 1'b0; nr1 = 1'b0; #2;
        check(val, 4'd9, "R10 nine kept after release");
        pulse(1'b0);
        check(val, 4'd0, "R10 count from nine");

        // R6 / R10
        for (int k = 0; k < 4; k++) pulse(1'b0);
        zr0 = 1'b1; zr1 = 1'b1; #2;
        check(val, 4'd0, "R6 clear");
        pulse(1'b0); pulse(1'b0);
        check(val, 4'd0, "R6 clear held");
        zr0 = 1'b0; zr1 = 1'b0; #2;
        pulse(1'b0);
        check(val, 4'd1, "R10 count from zero");

        // R8 priority
        nr0 = 1'b1; nr1 = 1'b1; zr0 = 1'b1; zr1 = 1'b1; #2;
        check(val, 4'd9, "R8 nine wins");
        nr0 = 1'b0; nr1 = 1'b0; #2;
        check(val, 4'd0, "R8 clear takes over");
        zr0 = 1'b0; zr1 = 1'b0; #2;

        // R9 single inputs of a pair
        pulse(1'b0); pulse(1'b0);
        zr0 = 1'b1; #2; pulse(1'b0);
        check(val, 4'd3, "R9 zero_req_0 alone");
        zr0 = 1'b0; zr1 = 1'b1; #2; pulse(1'b0);
        check(val, 4'd4, "R9 zero_req_1 alone");
        zr1 = 1'b0; nr0 = 1'b1; #2; pulse(1'b0);
        check(val, 4'd5, "R9 nine_req_0 alone");
        nr0 = 1'b0; nr1 = 1'b1; #2; pulse(1'b0);
        check(val, 4'd6, "R9 nine_req_1 alone");
        zr0 = 1'b1; #2; pulse(1'b0);
        check(val, 4'd7, "R9 one of each pair");
        zr0 = 1'b0; nr1 = 1'b0; #2;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule